// File: doc/BRIEF.md
# Two-Channel PWM Event Action Stage

This block sits between a PWM time-base counter and the output pins. On every clock it looks at the timing events: counter at zero, counter at period, and a compare match found from the counter value, the count direction and a per-channel compare value. Each event has a programmable action that decides the next level of pin A and pin B. A normal-polarity PWM wave sets the pin high at zero and at period, and clears it at the compare match. Swapping the high and low codes gives the inverted wave.

A continuous software force can pin either output low or high, whatever the events do. The force value on the input is not used directly. It is copied into an active force register at a reload point chosen by a 2-bit mode: counter zero, counter period, either of the two, or every clock. Both outputs are registered. Reset drives them low and clears the active force.

Top module: `pwm_event_shaper`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, both `pwm_a` and `pwm_b` are 0 and no force is active.
- R2: An action code of 2'b00 leaves the pin unchanged, 2'b01 drives it 0, 2'b10 drives it 1 and 2'b11 inverts it.
- R3: In each action word the zero-event code is bits 1:0 and the period-event code is bits 3:2. The up-count compare code is bits 5:4 of `act_a` for channel A and bits 9:8 of `act_b` for channel B. All other bits have no effect.
- R4: A compare event occurs only when `cnt_up` is 1 and `cnt_val` equals the channel's own compare value (`cmp_a` for A, `cmp_b` for B).
- R5: When events coincide, the pin follows the highest-priority event whose code is not 2'b00. The compare event ranks above the period event, which ranks above the zero event.
- R6: The force input holds channel A's code at bits 1:0 and channel B's at bits 3:2. An active code of 2'b01 forces the pin to 0, 2'b10 forces it to 1, and 2'b00 or 2'b11 means no force.
- R7: While a force is active on a channel, every event action on that channel is overridden.
- R8: `reload_mode` sets when the force input is copied into the active force. 2'b00 copies at a zero event, 2'b01 at a period event, 2'b10 at either event, and 2'b11 on every clock. At all other times the active force holds its value.
- R9: Event inputs present at clock edge t set the pins after edge t. A force value copied at edge t controls the pins from edge t+1.
- R10: With an up-counting counter from 0 to P, normal polarity words (0x001A for A, 0x010A for B) keep a pin high for C+1 of every P+1 clocks, where C is the compare value. Inverted words (0x0025, 0x0205) keep it low for C+1 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_zero | input | 1 | Counter-at-zero event |
| evt_period | input | 1 | Counter-at-period event |
| cnt_up | input | 1 | Count direction, 1 = up |
| cnt_val | input | CNT_W | Counter value |
| cmp_a | input | CNT_W | Compare value for channel A |
| cmp_b | input | CNT_W | Compare value for channel B |
| act_a | input | WORD_W | Action word for channel A |
| act_b | input | WORD_W | Action word for channel B |
| frc_word | input | FRC_W | Pending continuous-force codes |
| reload_mode | input | 2 | Reload point of the force codes |
| pwm_a | output | 1 | Output pin A |
| pwm_b | output | 1 | Output pin B |

## Verification
The hardest case to reach from the ports is a force code that sits waiting on the input while the active force still holds an older value. In that window, events keep acting (or stay masked) until the chosen reload event arrives. The stimulus reaches it by sweeping every force value under every reload mode, through a fixed event script. In that script the zero and period events arrive on different clocks, with toggling actions between them, so every early or late copy of the force changes a pin. A second sweep drives all 64 action-code combinations through all 16 combinations of zero, period, equality and direction. This makes priority and the direction qualifier on the compare event visible at the pins.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    RLD_ZERO   = 2'b00,
    RLD_PERIOD = 2'b01,
    RLD_EITHER = 2'b10,
    RLD_NOW    = 2'b11
  } reload_e;

  localparam int FIELD_W  = 2;
  localparam int ZERO_LSB = 0;
  localparam int PRD_LSB  = 2;

  function automatic logic apply_act(input act_e a, input logic cur);
    case (a)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

  function automatic int cmp_field_lsb(input int ch);
    return (ch == 0) ? 4 : 8;
  endfunction

endpackage

// File: rtl/pwm_cmp_detect.sv
module pwm_cmp_detect #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             cnt_up,
  output logic             hit
);
  always_comb hit = cnt_up && (cnt_val == cmp_val);
endmodule

// File: rtl/pwm_force_hold.sv
module pwm_force_hold
  import pwm_evt_pkg::*;
#(
  parameter int NCH = 2,
  localparam int FW = FIELD_W * NCH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] frc_in,
  input  logic [1:0]    mode,
  input  logic          evt_zero,
  input  logic          evt_period,
  output logic [FW-1:0] frc_act
);
  reload_e rmode;
  logic    take;

  always_comb begin
    rmode = reload_e'(mode);
    case (rmode)
      RLD_ZERO:   take = evt_zero;
      RLD_PERIOD: take = evt_period;
      RLD_EITHER: take = evt_zero | evt_period;
      default:    take = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       frc_act <= '0;
    else if (take) frc_act <= frc_in;
  end

  // R8: zero-point reload holds the active force between zero events
  assert_zero_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && !evt_zero) |=> $stable(frc_act));

  // R8: period-point reload holds the active force between period events
  assert_period_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && !evt_period) |=> $stable(frc_act));

  // R8: immediate reload copies the input on the next clock
  assert_immediate_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |=> (frc_act == $past(frc_in)));
endmodule

// File: rtl/pwm_chan_drive.sv
module pwm_chan_drive
  import pwm_evt_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int CMP_LSB = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] act_word,
  input  logic              evt_zero,
  input  logic              evt_period,
  input  logic              cmp_hit,
  input  logic [1:0]        frc_code,
  output logic              pin
);
  act_e a_zero, a_prd, a_cmp, chosen;
  logic pin_next;

  always_comb begin
    a_zero = act_e'(act_word[ZERO_LSB +: FIELD_W]);
    a_prd  = act_e'(act_word[PRD_LSB  +: FIELD_W]);
    a_cmp  = act_e'(act_word[CMP_LSB  +: FIELD_W]);
    // lowest priority first; later assignments win
    chosen = ACT_NONE;
    if (evt_zero   && a_zero != ACT_NONE) chosen = a_zero;
    if (evt_period && a_prd  != ACT_NONE) chosen = a_prd;
    if (cmp_hit    && a_cmp  != ACT_NONE) chosen = a_cmp;
    pin_next = apply_act(chosen, pin);
    if (frc_code == 2'b01) pin_next = 1'b0;
    else if (frc_code == 2'b10) pin_next = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pin <= 1'b0;
    else     pin <= pin_next;
  end

  // R7: an active low force wins over any event
  assert_force_low_R7: assert property (@(posedge clk) disable iff (rst)
    (frc_code == 2'b01) |=> (pin == 1'b0));

  // R7: an active high force wins over any event
  assert_force_high_R7: assert property (@(posedge clk) disable iff (rst)
    (frc_code == 2'b10) |=> (pin == 1'b1));

  // R2: with no event and no force the pin keeps its level
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!evt_zero && !evt_period && !cmp_hit && (frc_code == 2'b00 || frc_code == 2'b11))
      |=> $stable(pin));
endmodule

// File: rtl/pwm_event_shaper.sv
module pwm_event_shaper
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int WORD_W = 16,
  parameter int FRC_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_zero,
  input  logic              evt_period,
  input  logic              cnt_up,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic [CNT_W-1:0]  cmp_a,
  input  logic [CNT_W-1:0]  cmp_b,
  input  logic [WORD_W-1:0] act_a,
  input  logic [WORD_W-1:0] act_b,
  input  logic [FRC_W-1:0]  frc_word,
  input  logic [1:0]        reload_mode,
  output logic              pwm_a,
  output logic              pwm_b
);
  localparam int NCH = FRC_W / FIELD_W;

  logic [NCH-1:0][CNT_W-1:0]  cmp_arr;
  logic [NCH-1:0][WORD_W-1:0] act_arr;
  logic [NCH-1:0]             hit;
  logic [NCH-1:0]             pins;
  logic [FRC_W-1:0]           frc_act;

  always_comb begin
    cmp_arr[0] = cmp_a;
    cmp_arr[1] = cmp_b;
    act_arr[0] = act_a;
    act_arr[1] = act_b;
    pwm_a = pins[0];
    pwm_b = pins[1];
  end

  pwm_force_hold #(.NCH(NCH)) u_force (
    .clk        (clk),
    .rst        (rst),
    .frc_in     (frc_word),
    .mode       (reload_mode),
    .evt_zero   (evt_zero),
    .evt_period (evt_period),
    .frc_act    (frc_act)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pwm_cmp_detect #(.CNT_W(CNT_W)) u_cmp (
      .cnt_val (cnt_val),
      .cmp_val (cmp_arr[ch]),
      .cnt_up  (cnt_up),
      .hit     (hit[ch])
    );

    pwm_chan_drive #(.WORD_W(WORD_W), .CMP_LSB(cmp_field_lsb(ch))) u_drv (
      .clk        (clk),
      .rst        (rst),
      .act_word   (act_arr[ch]),
      .evt_zero   (evt_zero),
      .evt_period (evt_period),
      .cmp_hit    (hit[ch]),
      .frc_code   (frc_act[ch*FIELD_W +: FIELD_W]),
      .pin        (pins[ch])
    );
  end

  // R1: first clock out of reset sees both pins low
  assert_reset_low_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pwm_a && !pwm_b));
endmodule

// File: tb/pwm_event_shaper_test.sv
module pwm_event_shaper_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_zero = 1'b0, evt_period = 1'b0, cnt_up = 1'b0;
  logic [15:0] cnt_val = '0, cmp_a = '0, cmp_b = '0, act_a = '0, act_b = '0;
  logic [3:0]  frc_word = '0;
  logic [1:0]  reload_mode = '0;
  logic        pwm_a, pwm_b;

  int checks = 0, errors = 0, cycles = 0;
  logic m_a = 1'b0, m_b = 1'b0;
  logic [3:0] m_frc = '0;

  always #5 clk = ~clk;

  pwm_event_shaper uut (
    .clk(clk), .rst(rst), .evt_zero(evt_zero), .evt_period(evt_period),
    .cnt_up(cnt_up), .cnt_val(cnt_val), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .act_a(act_a), .act_b(act_b), .frc_word(frc_word),
    .reload_mode(reload_mode), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  function automatic logic next_lvl(input logic cur, input logic [15:0] w,
                                    input int clsb, input logic z, input logic p,
                                    input logic h, input logic [1:0] f);
    logic [1:0] c;
    logic r;
    c = 2'b00;
    if (z && w[1:0] != 2'b00) c = w[1:0];
    if (p && w[3:2] != 2'b00) c = w[3:2];
    if (h && w[clsb +: 2] != 2'b00) c = w[clsb +: 2];
    case (c)
      2'b01: r = 1'b0;
      2'b10: r = 1'b1;
      2'b11: r = ~cur;
      default: r = cur;
    endcase
    if (f == 2'b01) r = 1'b0;
    else if (f == 2'b10) r = 1'b1;
    return r;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp, input string pin);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pin %s: actual %0b expected %0b at cycle %0d", tag, pin, act, exp, cycles);
    end
  endtask

  task automatic tick(input string tag);
    logic ha, hb, ld;
    @(posedge clk);
    if (rst) begin
      m_a = 1'b0; m_b = 1'b0; m_frc = '0;
    end else begin
      ha = cnt_up && (cnt_val == cmp_a);
      hb = cnt_up && (cnt_val == cmp_b);
      m_a = next_lvl(m_a, act_a, 4, evt_zero, evt_period, ha, m_frc[1:0]);
      m_b = next_lvl(m_b, act_b, 8, evt_zero, evt_period, hb, m_frc[3:2]);
      case (reload_mode)
        2'b00: ld = evt_zero;
        2'b01: ld = evt_period;
        2'b10: ld = evt_zero | evt_period;
        default: ld = 1'b1;
      endcase
      if (ld) m_frc = frc_word;
    end
    #1;
    check(tag, pwm_a, m_a, "A");
    check(tag, pwm_b, m_b, "B");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int hi_a, hi_b;
    // R1: reset with busy inputs
    evt_zero = 1'b1; evt_period = 1'b1; act_a = 16'h003F; act_b = 16'h030F;
    frc_word = 4'hA; reload_mode = 2'b11;
    repeat (3) tick("R1");
    evt_zero = 1'b0; evt_period = 1'b0; frc_word = 4'h0;
    rst = 1'b0;
    tick("R1");

    // R2 R3 R4 R5: every code combination against every event pattern
    cmp_a = 16'd100;
    for (int codes = 0; codes < 64; codes++) begin
      act_a = 16'hA5C0 | 16'(((codes >> 4) & 3) << 4) | 16'(codes & 15);
      act_b = 16'hA4F0 | 16'(((codes >> 4) & 3) << 8) | 16'(codes & 15);
      cmp_b = codes[0] ? 16'd100 : 16'd7;
      for (int pat = 0; pat < 16; pat++) begin
        evt_zero   = pat[0];
        evt_period = pat[1];
        cnt_val    = pat[2] ? 16'd100 : 16'd55;
        cnt_up     = pat[3];
        repeat (2) tick("R2 R3 R4 R5");
      end
    end

    // R6 R7 R8 R9: all force values under all reload modes
    act_a = 16'h003F; act_b = 16'h030F; cmp_a = 16'd3; cmp_b = 16'd3;
    for (int md = 0; md < 4; md++) begin
      for (int fv = 0; fv < 16; fv++) begin
        reload_mode = 2'(md);
        frc_word = 4'(fv);
        for (int k = 0; k < 7; k++) begin
          evt_zero   = (k == 2);
          evt_period = (k == 4);
          cnt_up     = 1'b1;
          cnt_val    = (k == 1 || k == 5) ? 16'd3 : 16'd9;
          tick("R6 R7 R8 R9");
        end
      end
    end

    // R10: real up-count waveforms, normal then inverted polarity
    reload_mode = 2'b11; frc_word = 4'h0; evt_zero = 0; evt_period = 0; cnt_up = 1;
    cnt_val = 16'd50;
    repeat (2) tick("R10");
    cmp_a = 16'd4; cmp_b = 16'd7;
    for (int pol = 0; pol < 2; pol++) begin
      act_a = pol ? 16'h0025 : 16'h001A;
      act_b = pol ? 16'h0205 : 16'h010A;
      for (int per = 0; per < 3; per++) begin
        hi_a = 0; hi_b = 0;
        for (int c = 0; c <= 9; c++) begin
          cnt_val = 16'(c);
          evt_zero = (c == 0);
          evt_period = (c == 9);
          tick("R10");
          hi_a += int'(pwm_a);
          hi_b += int'(pwm_b);
        end
        if (per > 0) begin
          checks++;
          if (hi_a != (pol ? 5 : 5)) begin
            errors++;
            $display("FAIL R10 A high count: actual %0d expected %0d", hi_a, 5);
          end
          checks++;
          if (hi_b != (pol ? 2 : 8)) begin
            errors++;
            $display("FAIL R10 B high count: actual %0d expected %0d", hi_b, pol ? 2 : 8);
          end
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule